// File: doc/BRIEF.md
# Alarm Message Serial Transmitter

This block sends a fixed text message on an asynchronous serial line each time an alarm event occurs. A one-cycle (or longer) high level on the trigger input starts playback of a constant message held inside the block. Each byte is framed as one low start bit, eight data bits with the least significant bit first, and one high stop bit. There is no parity. Bytes follow one another with no idle time between them. A busy output covers the whole message.

The bit period in clocks is derived from two parameters, the clock frequency and the baud rate. By default the divisor is rounded to the nearest whole number, so a 10 MHz clock at 9600 baud gives 1042 clocks per bit. The message is a short ASCII string that always ends in carriage return and line feed. While a message is playing, further trigger pulses are dropped, so one alarm event yields exactly one message.

Top module: `msg_uart_tx`

## Requirements
- R1: While reset is asserted, and whenever no message is in progress, `tx` is high and `busy` is low.
- R2: A high `trig` sampled on a clock edge while `busy` is low starts a message. After that same edge, `busy` is high and `tx` is low, which is the first start bit.
- R3: Every bit holds for exactly CPB clocks, where CPB = round(CLK_HZ / BAUD). The defaults give 10,000,000 / 9600, which rounds to 1042.
- R4: Each byte is sent as a 10-bit frame: a low start bit, then the eight data bits with bit 0 first, then a high stop bit.
- R5: The default message is the 7 bytes 0x41 0x4C 0x41 0x52 0x4D 0x0D 0x0A ("ALARM", then CR, then LF). They are sent in that order, so the final two bytes are always carriage return and line feed.
- R6: The start bit of each byte after the first begins in the clock right after the previous stop bit ends, with no idle bit between frames.
- R7: `busy` stays high from the first start bit until the last stop bit ends. It falls exactly 10 × 7 × CPB clocks after it rose.
- R8: A high `trig` sampled while `busy` is high has no effect. This includes a trigger in the last busy cycle. The bytes sent and the time at which `busy` falls are unchanged, and no second message follows.
- R9: Asserting `rst_n` low in the middle of a message abandons it at once. `tx` returns high and `busy` low, and the line stays idle after release until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Alarm event; starts a message when idle |
| tx | output | 1 | Serial data out, idles high |
| busy | output | 1 | High while a message is being sent |

## Verification
The hardest situation to reach is a trigger that arrives on the very edge at which `busy` falls. At that edge the block still counts as busy, so the trigger must be dropped and must not start a second message. The driver counts clocks from the first start bit and raises `trig` on exactly the last busy cycle. It then watches the line for several bit times and expects no new start bit. A scoreboard monitor decodes every frame at mid-bit and checks each gapless byte boundary. A second instance with the default parameters measures the real 1042-clock start bit.

// File: rtl/msg_uart_pkg.sv
package msg_uart_pkg;
   localparam int MSG_LEN    = 7;
   localparam int FRAME_BITS = 10;

   typedef logic [7:0] byte_t;

   // Message text: "ALARM" then CR, LF
   function automatic byte_t msg_byte(input int unsigned idx);
      case (idx)
         0:       return 8'h41;
         1:       return 8'h4C;
         2:       return 8'h41;
         3:       return 8'h52;
         4:       return 8'h4D;
         5:       return 8'h0D;
         6:       return 8'h0A;
         default: return 8'hFF;
      endcase
   endfunction
endpackage

// File: rtl/baud_timer.sv
module baud_timer #(
   parameter int CPB = 1042
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (CPB < 1) begin : g_bad_cpb
         $error("baud_timer: CPB must be at least 1");
      end

      if (CPB == 1) begin : g_every_clock
         assign tick = run;
      end else begin : g_counter
         localparam int CW = $clog2(CPB);
         localparam logic [CW-1:0] TOP = CW'(CPB - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (!run || tick)     cnt <= '0;
            else                       cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == TOP);

         // R3: the count never passes the bit boundary
         a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
            run |-> cnt <= TOP);
      end
   endgenerate
endmodule

// File: rtl/msg_table.sv
module msg_table
   import msg_uart_pkg::*;
#(
   parameter int N  = MSG_LEN,
   parameter int IW = 3
) (
   input  logic [IW-1:0] idx,
   output byte_t         data
);
   byte_t tbl [N];

   generate
      for (genvar g = 0; g < N; g++) begin : g_entry
         assign tbl[g] = msg_byte(g);
      end
   endgenerate

   always_comb begin
      if (int'(idx) < N) data = tbl[idx];
      else               data = 8'hFF;
   end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
   import msg_uart_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  byte_t data,
   input  logic  tick,
   output logic  tx,
   output logic  done,
   output logic  active
);
   localparam int BW = $clog2(FRAME_BITS);
   localparam logic [BW-1:0] LAST_POS = BW'(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] sh;
   logic [BW-1:0]         pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '1;
         pos    <= '0;
         active <= 1'b0;
      end else if (load) begin
         sh     <= {1'b1, data, 1'b0};
         pos    <= '0;
         active <= 1'b1;
      end else if (tick && active) begin
         if (pos == LAST_POS) begin
            active <= 1'b0;
         end else begin
            sh  <= {1'b1, sh[FRAME_BITS-1:1]};
            pos <= pos + 1'b1;
         end
      end
   end

   assign done = tick && active && (pos == LAST_POS);
   assign tx   = active ? sh[0] : 1'b1;

   // R4: a freshly loaded frame opens with a low start bit
   a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !tx);
   // R4: final frame position is the high stop bit
   a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      (active && pos == LAST_POS) |-> tx);
endmodule

// File: rtl/msg_uart_tx.sv
module msg_uart_tx
   import msg_uart_pkg::*;
#(
   parameter int CLK_HZ    = 10_000_000,
   parameter int BAUD      = 9600,
   parameter bit ROUND_DIV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic tx,
   output logic busy
);
   localparam int CPB = ROUND_DIV ? (CLK_HZ + BAUD / 2) / BAUD : CLK_HZ / BAUD;
   localparam int IW  = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(MSG_LEN - 1);

   generate
      if (BAUD <= 0 || CLK_HZ <= 0) begin : g_bad_rate
         $error("msg_uart_tx: rates must be positive");
      end
      if (CPB < 2) begin : g_bad_ratio
         $error("msg_uart_tx: clock too slow for baud rate");
      end
      if (MSG_LEN < 2) begin : g_bad_len
         $error("msg_uart_tx: message must hold at least CR LF");
      end
   endgenerate

   logic          busy_q;
   logic [IW-1:0] idx;
   logic          start, last, load, tick, done, active;
   logic [IW-1:0] nxt_idx;
   byte_t         nxt_byte;

   assign start   = trig && !busy_q;
   assign last    = (idx == LAST_IDX);
   assign load    = start || (done && !last);
   assign nxt_idx = start ? '0 : idx + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx    <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         idx    <= '0;
      end else if (done) begin
         if (last) busy_q <= 1'b0;
         else      idx    <= idx + 1'b1;
      end
   end

   msg_table #(.N(MSG_LEN), .IW(IW)) table_i (
      .idx  (nxt_idx),
      .data (nxt_byte)
   );

   baud_timer #(.CPB(CPB)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_q),
      .tick  (tick)
   );

   frame_shifter shifter_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .data   (nxt_byte),
      .tick   (tick),
      .tx     (tx),
      .done   (done),
      .active (active)
   );

   assign busy = busy_q;

   // R1: line high whenever no message runs
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> tx);
   // R3: line only moves on a bit boundary or a load
   a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !tick && !start) |=> $stable(tx));
   // R6: next start bit follows a stop bit without a gap
   a_r6_gapless: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !last) |=> !tx);
   // R7: busy drops right after the last stop bit
   a_r7_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      (done && last) |=> !busy_q);
   // R8: triggers during a message change nothing
   a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> (busy_q && $stable(idx)));
   // R2: framer is active exactly while busy
   a_r2_active_busy: assert property (@(posedge clk) disable iff (!rst_n)
      active == busy_q);
endmodule

// File: tb/msg_uart_tx_tb_top.sv
module msg_uart_tx_tb_top;
   localparam int T_CLK_HZ = 160_000;
   localparam int T_BAUD   = 10_000;
   localparam int CPB      = 16;
   localparam int NBYTES   = 7;
   localparam int TOT      = 10 * NBYTES * CPB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig = 1'b0;
   logic trig2 = 1'b0;
   logic tx, busy, tx2, busy2;

   int checks = 0;
   int errors = 0;
   bit mon_on = 1'b0;
   logic [7:0] exp_q [$];
   logic [7:0] msg [NBYTES] = '{8'h41, 8'h4C, 8'h41, 8'h52, 8'h4D, 8'h0D, 8'h0A};

   always #4 clk = ~clk;

   msg_uart_tx #(.CLK_HZ(T_CLK_HZ), .BAUD(T_BAUD)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig(trig), .tx(tx), .busy(busy));

   msg_uart_tx dut_def_i (
      .clk(clk), .rst_n(rst_n), .trig(trig2), .tx(tx2), .busy(busy2));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // Driver: pushes expected bytes, triggers, times busy
   task automatic send_msg(input int hold, input int extra);
      for (int b = 0; b < NBYTES; b++) exp_q.push_back(msg[b]);
      @(negedge clk);
      trig = 1'b1;
      for (int i = 0; i <= TOT; i++) begin
         @(negedge clk);
         if (i == 0) begin
            check(busy === 1'b1, "R2 busy after trigger", busy, 1);
            check(tx === 1'b0, "R2 start bit after trigger", tx, 0);
         end
         if (i == hold - 1) trig = 1'b0;
         if (extra > 0 && i == extra) trig = 1'b1;
         if (extra > 0 && i == extra + 1) trig = 1'b0;
         if (i == TOT - 1) check(busy === 1'b1, "R7 busy held to last stop", busy, 1);
         if (i == TOT) check(busy === 1'b0, "R7 busy falls on time", busy, 0);
      end
      trig = 1'b0;
      // R8: no second message after the one triggered
      for (int i = 0; i < 3 * CPB; i++) begin
         @(negedge clk);
         if (tx !== 1'b1 || busy !== 1'b0) begin
            check(1'b0, "R8 no restart after end", tx, 1);
            break;
         end
      end
      check(exp_q.size() == 0, "R5 all bytes received", exp_q.size(), 0);
   endtask

   // Monitor: decodes frames at mid-bit and compares with the queue
   initial begin : monitor
      logic prev;
      logic [7:0] got;
      prev = 1'b1;
      forever begin
         @(negedge clk);
         if (mon_on && prev === 1'b1 && tx === 1'b0) begin
            bit more;
            more = 1'b1;
            while (more) begin
               repeat (CPB / 2) @(negedge clk);
               check(tx === 1'b0, "R4 start bit low", tx, 0);
               for (int b = 0; b < 8; b++) begin
                  repeat (CPB) @(negedge clk);
                  got[b] = tx;
               end
               repeat (CPB) @(negedge clk);
               check(tx === 1'b1, "R4 stop bit high", tx, 1);
               if (exp_q.size() == 0) begin
                  check(1'b0, "R5 unexpected byte", got, 0);
                  more = 1'b0;
               end else begin
                  logic [7:0] e;
                  e = exp_q.pop_front();
                  check(got === e, "R5 R4 byte value", got, e);
                  more = (exp_q.size() != 0);
               end
               if (more) begin
                  repeat (CPB - CPB / 2) @(negedge clk);
                  check(tx === 1'b0, "R6 gapless next start", tx, 0);
               end
            end
         end
         prev = tx;
      end
   end

   initial begin : watchdog
      repeat (150_000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin : main
      int lowcnt;
      repeat (3) @(negedge clk);
      check(tx === 1'b1, "R1 tx high in reset", tx, 1);
      check(busy === 1'b0, "R1 busy low in reset", busy, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(tx === 1'b1 && busy === 1'b0, "R1 idle after reset", tx, 1);
      mon_on = 1'b1;

      send_msg(1, 0);                 // single-cycle trigger
      send_msg(6, 0);                 // trigger held several cycles
      send_msg(1, 3 * 10 * CPB + 5);  // R8 trigger mid-message
      send_msg(1, TOT - 1);           // R8 trigger in last busy cycle

      // R9: reset during a message
      mon_on = 1'b0;
      @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      repeat (2 * 10 * CPB + 3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(tx === 1'b1, "R9 tx high on mid reset", tx, 1);
      check(busy === 1'b0, "R9 busy low on mid reset", busy, 0);
      rst_n = 1'b1;
      begin
         bit quiet;
         quiet = 1'b1;
         for (int i = 0; i < 4 * 10 * CPB; i++) begin
            @(negedge clk);
            if (tx !== 1'b1 || busy !== 1'b0) quiet = 1'b0;
         end
         check(quiet, "R9 idle after reset release", quiet, 1);
      end
      mon_on = 1'b1;
      send_msg(1, 0);                 // R9 restart works after reset

      // R3: default parameters give a 1042-clock start bit
      @(negedge clk);
      trig2 = 1'b1;
      @(negedge clk);
      trig2 = 1'b0;
      lowcnt = 0;
      for (int i = 0; i < 3000; i++) begin
         if (tx2 !== 1'b0) break;
         lowcnt++;
         @(negedge clk);
      end
      check(lowcnt == 1042, "R3 default bit period", lowcnt, 1042);
      check(busy2 === 1'b1, "R3 default instance busy", busy2, 1);

      summary();
      $finish;
   end
endmodule